// File: doc/BRIEF.md
# Chip Select and Wait State Generator

This block decodes external bus accesses into four active-low device selects and ends each access on behalf of the bus master. Every channel holds a base address, a power-of-two block size between 256 bytes and the whole 4 GB space, an optional address-space filter, a write-protect flag, the port width of the device behind it and a termination method. When the address strobe falls, the block takes a snapshot of the address and qualifiers. It picks the lowest-numbered matching channel and drives that select low from the next clock until the strobe is released.

The termination output both ends the cycle and tells the master the port width of the device. It can fire in the first selected cycle, after a counted number of wait states, or one clock after an external acknowledge input is seen low. A write that hits a write-protected channel raises a bus error instead. An access that hits no channel gets no response at all, so other logic can decide what happens. Channel 0 comes out of reset enabled over the whole address space, so the system can boot. Its port width is taken from a strap input while reset is held.

Top module: `csel_wait_unit`

## Requirements
- R1: While rst_n is low (sampled on a clock edge), all selects are high, term is 00 and berr is 0. Channel 0 becomes enabled over the whole 4 GB space with 6 counted wait states and no space or write checks, and its width comes from boot_width, where 00 is taken as 32-bit. Channels 1 to 3 become disabled.
- R2: Configuration is written with cfg_we high on a clock edge. cfg_addr[2:1] is the channel and cfg_addr[0] selects the base register (0) or the control register (1). In the base register, bits [31:8] are the base and bits [5:0] are the block-size exponent E, clamped to 8..32. A channel matches when address bits 31..E equal the same bits of the base.
- R3: Control bit 0 enables the channel. When control bit 2 is set, the channel matches only if bus_space equals control bits [5:3].
- R4: When several channels match, only the lowest-numbered one asserts its select, and at most one select is ever low.
- R5: The select goes low in the cycle after the clock edge that first sees bus_as_n low. It stays low while bus_as_n stays low, and goes high in the cycle after the edge that sees bus_as_n high.
- R6: Control bits [9:8] = 00 select fast termination: term shows the width code in the first selected cycle for exactly one clock. Control bits [7:6] hold the width code (01 = 8-bit, 10 = 16-bit, 11 = 32-bit, 00 is stored as 11).
- R7: Control bits [9:8] = 01 select counted termination with N = control bits [12:10] wait states (0 is taken as 1, 7 as 6). term appears N cycles later than in fast mode, for one clock.
- R8: Control bits [9:8] = 1x select handshake termination: term shows the width code for one clock in the cycle after the edge that sees ext_ack_n low. Without an acknowledge, term stays 00 while the select stays low.
- R9: When control bit 1 is set, a write (bus_write high) that matches the channel asserts no select and gives no termination. Instead, berr is high for one clock in the first cycle. Reads of that channel behave normally.
- R10: An access that matches no enabled channel asserts no select, no termination and no berr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Channel and register select for configuration |
| cfg_wdata | input | 32 | Configuration write data |
| boot_width | input | 2 | Width strap for channel 0, sampled during reset |
| bus_as_n | input | 1 | Active-low address strobe |
| bus_addr | input | 32 | Access address |
| bus_space | input | 3 | Address-space qualifier of the access |
| bus_write | input | 1 | High for a write access |
| ext_ack_n | input | 1 | Active-low external transfer acknowledge |
| cs_n | output | 4 | Active-low chip selects, bit i for channel i |
| term | output | 2 | Termination and port width code |
| berr | output | 1 | One-clock bus error for protected writes |

## Verification
Accesses are aimed just inside and just outside several block sizes (256 B, 64 KB, 1 MB, 16 MB, whole space). This separates a correct mask position from an off-by-one exponent. The same channel is used with each termination method: fast, three waits, six waits at boot, and a handshake acknowledged late or never. This pins the exact term cycle and shows that a counted mode cannot be mistaken for a fast one. Writes against reads on a protected channel, matching against differing address spaces, and two overlapping channels separate qualification errors from priority errors. A second reset with a zero strap checks the default width.

// File: rtl/csel_pkg.sv
// Shared constants, configuration record and field decoders for the
// chip select unit. Assumes a 32-bit address bus and 32-bit config data.
package csel_pkg;

    localparam int ADDR_W   = 32;
    localparam int BLK_MIN  = 8;
    localparam int EXP_W    = 6;
    localparam int WAIT_W   = 3;
    localparam int WAIT_MAX = 6;
    localparam int SPACE_W  = 3;

    typedef enum logic [1:0] {
        TM_FAST  = 2'b00,
        TM_COUNT = 2'b01,
        TM_EXT   = 2'b10
    } term_mode_e;

    typedef struct packed {
        logic                      en;
        logic                      wprot;
        logic                      sp_chk;
        logic [SPACE_W-1:0]        sp;
        logic [ADDR_W-1:BLK_MIN]   base;
        logic [EXP_W-1:0]          blk_exp;
        logic [1:0]                width;
        term_mode_e                mode;
        logic [WAIT_W-1:0]         waits;
    } chan_cfg_t;

    // Width code 00 is not a legal port width; treat it as 32-bit.
    function automatic logic [1:0] fix_width(logic [1:0] w);
        return (w == 2'b00) ? 2'b11 : w;
    endfunction

    // Keep the size exponent between 256 bytes and the full space.
    function automatic logic [EXP_W-1:0] fix_exp(logic [EXP_W-1:0] e);
        if (e < EXP_W'(BLK_MIN)) return EXP_W'(BLK_MIN);
        if (e > EXP_W'(ADDR_W))  return EXP_W'(ADDR_W);
        return e;
    endfunction

    // Keep the wait count within 1..WAIT_MAX.
    function automatic logic [WAIT_W-1:0] fix_waits(logic [WAIT_W-1:0] n);
        if (n == '0) return WAIT_W'(1);
        if (n > WAIT_W'(WAIT_MAX)) return WAIT_W'(WAIT_MAX);
        return n;
    endfunction

    // Both upper mode codes mean handshake termination.
    function automatic term_mode_e fix_mode(logic [1:0] m);
        case (m)
            2'b00:   return TM_FAST;
            2'b01:   return TM_COUNT;
            default: return TM_EXT;
        endcase
    endfunction

    // Reset contents of the boot channel.
    function automatic chan_cfg_t boot_cfg(logic [1:0] strap);
        chan_cfg_t c;
        c         = '0;
        c.en      = 1'b1;
        c.blk_exp = EXP_W'(ADDR_W);
        c.width   = fix_width(strap);
        c.mode    = TM_COUNT;
        c.waits   = WAIT_W'(WAIT_MAX);
        return c;
    endfunction

    // Apply a base/size register write to a channel record.
    function automatic chan_cfg_t put_base(chan_cfg_t c, logic [31:0] d);
        chan_cfg_t r;
        r         = c;
        r.base    = d[ADDR_W-1:BLK_MIN];
        r.blk_exp = fix_exp(d[EXP_W-1:0]);
        return r;
    endfunction

    // Apply a control register write to a channel record.
    function automatic chan_cfg_t put_ctrl(chan_cfg_t c, logic [31:0] d);
        chan_cfg_t r;
        r        = c;
        r.en     = d[0];
        r.wprot  = d[1];
        r.sp_chk = d[2];
        r.sp     = d[5:3];
        r.width  = fix_width(d[7:6]);
        r.mode   = fix_mode(d[9:8]);
        r.waits  = fix_waits(d[12:10]);
        return r;
    endfunction

endpackage

// File: rtl/csel_cfg_regs.sv
// Configuration store for all channels. Assumes cfg_addr = {channel, reg},
// reg 0 = base/size, reg 1 = control. Channel 0 resets to the boot setup.
module csel_cfg_regs
    import csel_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CAW = $clog2(NCH) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CAW-1:0]        addr,
    input  logic [31:0]           wdata,
    input  logic [1:0]            boot_width,
    output chan_cfg_t [NCH-1:0]   cfg_o
);

    chan_cfg_t [NCH-1:0] cfg_q;

    // Reset loads boot defaults; writes update one register of one channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                cfg_q[i] <= (i == 0) ? boot_cfg(boot_width) : '0;
            end
        end else if (we) begin
            if (addr[0])
                cfg_q[addr[CAW-1:1]] <= put_ctrl(cfg_q[addr[CAW-1:1]], wdata);
            else
                cfg_q[addr[CAW-1:1]] <= put_base(cfg_q[addr[CAW-1:1]], wdata);
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/csel_match.sv
// Address decoder for one channel. Pure combinational compare of the
// upper address bits against the base, above a power-of-two boundary,
// plus the optional address-space filter.
module csel_match
    import csel_pkg::*;
(
    input  logic                     en,
    input  logic                     sp_chk,
    input  logic [SPACE_W-1:0]       sp,
    input  logic [ADDR_W-1:BLK_MIN]  base,
    input  logic [EXP_W-1:0]         blk_exp,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [SPACE_W-1:0]       space,
    output logic                     hit
);

    logic [ADDR_W-1:BLK_MIN] keep;
    logic [ADDR_W-1:BLK_MIN] diff;

    // Compare only the bits at or above the block-size exponent.
    always_comb begin
        for (int b = BLK_MIN; b < ADDR_W; b++) begin
            keep[b] = (blk_exp <= EXP_W'(b));
        end
        diff = (addr[ADDR_W-1:BLK_MIN] ^ base) & keep;
        hit  = en && (diff == '0) && (!sp_chk || (space == sp));
    end

endmodule

// File: rtl/csel_term.sv
// Termination sequencer. On start it either flags a bus error, answers
// at once, counts wait states, or waits for the handshake. It assumes
// start comes at most once per address strobe. An early strobe release
// cancels a pending answer.
module csel_term
    import csel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_berr,
    input  term_mode_e         mode,
    input  logic [WAIT_W-1:0]  waits,
    input  logic [1:0]         width,
    input  logic               ext_ack_n,
    input  logic               as_n,
    output logic [1:0]         term,
    output logic               berr
);

    logic               busy_q;
    term_mode_e         mode_q;
    logic [WAIT_W-1:0]  cnt_q;
    logic [1:0]         width_q;
    logic [1:0]         term_q;
    logic               berr_q;

    // Sequence one termination or error pulse per started access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            mode_q  <= TM_FAST;
            cnt_q   <= '0;
            width_q <= '0;
            term_q  <= '0;
            berr_q  <= 1'b0;
        end else begin
            term_q <= '0;
            berr_q <= 1'b0;
            if (start) begin
                busy_q  <= 1'b0;
                width_q <= width;
                mode_q  <= mode;
                cnt_q   <= waits;
                if (start_berr)
                    berr_q <= 1'b1;
                else if (mode == TM_FAST)
                    term_q <= width;
                else
                    busy_q <= 1'b1;
            end else if (busy_q) begin
                if (as_n) begin
                    busy_q <= 1'b0;
                end else if (mode_q == TM_COUNT) begin
                    if (cnt_q <= WAIT_W'(1)) begin
                        term_q <= width_q;
                        busy_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else if (!ext_ack_n) begin
                    term_q <= width_q;
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign term = term_q;
    assign berr = berr_q;

    // R6 R7 R8: every termination lasts exactly one clock.
    a_r6_term_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (term_q != 2'b00) |=> (term_q == 2'b00));

    // R9: a bus error never comes with a termination.
    a_r9_berr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(berr_q && (term_q != 2'b00)));

    // R9: a bus error only follows a protected start.
    a_r9_berr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        berr_q |-> $past(start && start_berr));

    // R7: the pending wait count stays inside its legal range.
    a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (mode_q == TM_COUNT)) |-> ((cnt_q >= WAIT_W'(1)) && (cnt_q <= WAIT_W'(WAIT_MAX))));

endmodule

// File: rtl/csel_wait_unit.sv
// Top of the chip select unit. It takes one snapshot of the decode at the
// first edge with the address strobe low, then holds the winning select
// until the strobe rises. Assumes address and qualifiers are stable while
// the strobe is low.
module csel_wait_unit
    import csel_pkg::*;
#(
    parameter int NCH = 4,
    localparam int IDXW = $clog2(NCH),
    localparam int CAW  = IDXW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CAW-1:0]       cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic [1:0]           boot_width,
    input  logic                 bus_as_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [SPACE_W-1:0]   bus_space,
    input  logic                 bus_write,
    input  logic                 ext_ack_n,
    output logic [NCH-1:0]       cs_n,
    output logic [1:0]           term,
    output logic                 berr
);

    chan_cfg_t [NCH-1:0] cfg;
    logic [NCH-1:0]      hit;
    logic [IDXW-1:0]     win_idx;
    logic                win_valid;
    logic                wp_block;
    logic                capture;
    logic                active_q;
    logic [NCH-1:0]      sel_q;

    csel_cfg_regs #(.NCH(NCH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .boot_width (boot_width),
        .cfg_o      (cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        csel_match u_match (
            .en      (cfg[g].en),
            .sp_chk  (cfg[g].sp_chk),
            .sp      (cfg[g].sp),
            .base    (cfg[g].base),
            .blk_exp (cfg[g].blk_exp),
            .addr    (bus_addr),
            .space   (bus_space),
            .hit     (hit[g])
        );
    end

    // Lowest-numbered matching channel wins.
    always_comb begin
        win_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hit[i]) win_idx = IDXW'(i);
        end
        win_valid = |hit;
        wp_block  = win_valid && cfg[win_idx].wprot && bus_write;
        capture   = !bus_as_n && !active_q;
    end

    // Latch the select at strobe entry, clear it when the strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sel_q    <= '0;
        end else if (bus_as_n) begin
            active_q <= 1'b0;
            sel_q    <= '0;
        end else if (capture) begin
            active_q <= 1'b1;
            if (win_valid && !wp_block)
                sel_q <= NCH'(1) << win_idx;
        end
    end

    csel_term u_term (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (capture && win_valid),
        .start_berr (wp_block),
        .mode       (cfg[win_idx].mode),
        .waits      (cfg[win_idx].waits),
        .width      (cfg[win_idx].width),
        .ext_ack_n  (ext_ack_n),
        .as_n       (bus_as_n),
        .term       (term),
        .berr       (berr)
    );

    assign cs_n = ~sel_q;

    // R4: never more than one select low.
    a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_q));

    // R5: a released strobe drops every select by the next cycle.
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as_n |=> (cs_n == '1));

    // R9: a bus error cycle never has a select low.
    a_r9_no_select_on_berr: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> (cs_n == '1));

    // R10: nothing answers while no channel is selected or erroring in the first cycle.
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as_n && !active_q) |=> (term == 2'b00) && !berr);

endmodule

// File: tb/tb_csel_wait_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_csel_wait_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  boot_width = 2'b10;
    logic        bus_as_n = 1'b1;
    logic [31:0] bus_addr = '0;
    logic [2:0]  bus_space = '0;
    logic        bus_write = 1'b0;
    logic        ext_ack_n = 1'b1;
    logic [3:0]  cs_n;
    logic [1:0]  term;
    logic        berr;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    csel_wait_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .boot_width (boot_width),
        .bus_as_n   (bus_as_n),
        .bus_addr   (bus_addr),
        .bus_space  (bus_space),
        .bus_write  (bus_write),
        .ext_ack_n  (ext_ack_n),
        .cs_n       (cs_n),
        .term       (term),
        .berr       (berr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] strap);
        @(negedge clk);
        boot_width = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_wr(input int ch, input bit ctrl, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {2'(ch), ctrl};
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // One strobe cycle; term/berr indices count negedges after the capture edge.
    task automatic access(input logic [31:0] a, input logic [2:0] sp, input bit wr,
                          input int ack_at, input int hold, input logic [3:0] exp_cs,
                          input int exp_tidx, input logic [1:0] exp_term,
                          input bit exp_berr, input string req);
        int tidx = 0, tcnt = 0, bidx = 0, bcnt = 0;
        logic [1:0] tval = 2'b00;
        logic [3:0] bad_cs = exp_cs;
        bit cs_ok = 1'b1;
        @(negedge clk);
        bus_addr = a; bus_space = sp; bus_write = wr; bus_as_n = 1'b0;
        for (int i = 1; i <= hold; i++) begin
            @(negedge clk);
            if (cs_n !== exp_cs) begin cs_ok = 1'b0; bad_cs = cs_n; end
            if (term !== 2'b00) begin
                tcnt++;
                if (tidx == 0) begin tidx = i; tval = term; end
            end
            if (berr) begin bcnt++; bidx = i; end
            if (i == ack_at) ext_ack_n = 1'b0;
        end
        chk(cs_ok, req, "select held", int'(bad_cs), int'(exp_cs));
        chk(tidx == exp_tidx && tcnt == (exp_tidx != 0 ? 1 : 0), req,
            "term cycle", tidx, exp_tidx);
        if (exp_tidx != 0) chk(tval == exp_term, req, "term code", int'(tval), int'(exp_term));
        chk(bcnt == (exp_berr ? 1 : 0) && bidx == (exp_berr ? 1 : 0), req,
            "berr pulse", bidx, exp_berr ? 1 : 0);
        bus_as_n = 1'b1; ext_ack_n = 1'b1;
        @(negedge clk);
        chk(cs_n === 4'hF, "R5", "select released", int'(cs_n), 15);
    endtask

    task automatic t_reset_state;
        do_reset(2'b10);
        chk(cs_n === 4'hF && term === 2'b00 && berr === 1'b0, "R1", "reset outputs",
            int'({cs_n, term, berr}), int'({4'hF, 2'b00, 1'b0}));
        access(32'h1234_5678, 3'd0, 1'b0, -1, 10, 4'b1110, 7, 2'b10, 1'b0, "R1");
    endtask

    task automatic t_fast_decode;
        cfg_wr(0, 1'b1, 32'h0);
        cfg_wr(1, 1'b0, 32'h0010_0014);
        cfg_wr(1, 1'b1, 32'h0000_0041);
        access(32'h0010_0ABC, 3'd0, 1'b0, -1, 4, 4'b1101, 1, 2'b01, 1'b0, "R6");
        access(32'h001F_FFFF, 3'd0, 1'b1, -1, 4, 4'b1101, 1, 2'b01, 1'b0, "R2");
        access(32'h0020_0000, 3'd0, 1'b0, -1, 4, 4'b1111, 0, 2'b00, 1'b0, "R10");
        access(32'h000F_FFFF, 3'd0, 1'b0, -1, 4, 4'b1111, 0, 2'b00, 1'b0, "R10");
    endtask

    task automatic t_counted;
        cfg_wr(2, 1'b0, 32'h8000_0010);
        cfg_wr(2, 1'b1, 32'h0000_0DC1);
        access(32'h8000_FFFC, 3'd2, 1'b0, -1, 7, 4'b1011, 4, 2'b11, 1'b0, "R7");
        access(32'h8001_0000, 3'd2, 1'b0, -1, 7, 4'b1111, 0, 2'b00, 1'b0, "R2");
    endtask

    task automatic t_handshake;
        cfg_wr(3, 1'b0, 32'hC000_0008);
        cfg_wr(3, 1'b1, 32'h0000_0281);
        access(32'hC000_00FF, 3'd0, 1'b0, 5, 8, 4'b0111, 6, 2'b10, 1'b0, "R8");
        access(32'hC000_0000, 3'd0, 1'b0, -1, 8, 4'b0111, 0, 2'b00, 1'b0, "R8");
        access(32'hC000_0100, 3'd0, 1'b0, 2, 6, 4'b1111, 0, 2'b00, 1'b0, "R2");
    endtask

    task automatic t_space;
        cfg_wr(1, 1'b1, 32'h0000_006D);
        access(32'h0010_0000, 3'd5, 1'b0, -1, 4, 4'b1101, 1, 2'b01, 1'b0, "R3");
        access(32'h0010_0000, 3'd1, 1'b0, -1, 4, 4'b1111, 0, 2'b00, 1'b0, "R3");
    endtask

    task automatic t_protect;
        cfg_wr(2, 1'b1, 32'h0000_0DC3);
        access(32'h8000_0000, 3'd0, 1'b1, -1, 7, 4'b1111, 0, 2'b00, 1'b1, "R9");
        access(32'h8000_0000, 3'd0, 1'b0, -1, 7, 4'b1011, 4, 2'b11, 1'b0, "R9");
    endtask

    task automatic t_priority;
        cfg_wr(1, 1'b0, 32'h8000_0018);
        cfg_wr(1, 1'b1, 32'h0000_0041);
        access(32'h8000_0010, 3'd0, 1'b0, -1, 6, 4'b1101, 1, 2'b01, 1'b0, "R4");
        access(32'h8100_0000, 3'd0, 1'b0, -1, 4, 4'b1111, 0, 2'b00, 1'b0, "R4");
    endtask

    task automatic t_boot_default_width;
        do_reset(2'b00);
        access(32'hFFFF_FF00, 3'd7, 1'b1, -1, 10, 4'b1110, 7, 2'b11, 1'b0, "R1");
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_fast_decode();
        t_counted();
        t_handshake();
        t_space();
        t_protect();
        t_priority();
        t_boot_default_width();
        summary();
        $finish;
    end

endmodule